// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects a set of asynchronous interrupt request lines, plus one line that cannot be masked, and folds them into one service request toward a processor. Each line can act on its level or on its edges, with either polarity. Edges are recorded in a sticky pending bit, so an event that arrives while its line is disabled still waits for service. A mask enables or disables each maskable line. Among the enabled requests, the lowest index wins, and its index is presented together with a request flag.

The processor sees a request only while it drives the boundary strobe high, which marks the places where it can take an interrupt. When it takes one, it pulses the acknowledge input in the same cycle. This clears the pending bit of the line being presented. Software can also clear pending bits with a write-one-to-clear through the small configuration write port. The status output shows, for each line, whether it is requesting service, before the mask is applied.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Every raw request input passes through two synchronizing flops. A level-mode, active-high line that rises before clock edge k shows on `status_o` after edge k+1, and does not show after edge k.
- R2: A line in level mode (mode bit 0) requests service for exactly as long as its synchronized input sits at its active level. When the input is released, the request drops.
- R3: A line in edge mode (mode bit 1) sets its pending bit once for each inactive-to-active transition. The bit stays set after the input returns to inactive. An input held active does not set the bit again after it has been cleared.
- R4: Mask bits with the default parameter setting: a 1 enables the line. A line that is masked never raises `irq_o`, but its pending bit is kept and its status is still shown. When the line is unmasked, it is presented.
- R5: The non-maskable input ignores the mask and ranks above every other line. While it is active, `nmi_o` and `irq_o` are both high. An acknowledge given while it is active clears no pending bit.
- R6: When several enabled requests are active, `irq_idx_o` gives the lowest index among them, in binary. The index reads 0 when no maskable line is selected.
- R7: When `boundary_i` is low, `irq_o` and `nmi_o` are both low. Pending state is unchanged.
- R8: An acknowledge cycle, where `ack_i` is high while `irq_o` is high and no non-maskable request is active, clears the pending bit of the presented line. If a new edge on that same line is detected in that same cycle, the bit stays set.
- R9: A configuration write selects its target with `cfg_sel_i` as follows: 0 = mask, 1 = mode (1 = edge), 2 = polarity (1 = active-low or falling edge), 3 = pending clear. A write to 3 clears each pending bit whose data bit is 1.
- R10: A line with polarity bit 1 requests service while its input is low. In edge mode, such a line reacts to falling edges.
- R11: After reset, every line is masked, in level mode and active-high, with no pending bits. `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_raw_i | input | N_LINES | Raw maskable request lines |
| nmi_raw_i | input | 1 | Raw non-maskable request, active high |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Write target: 0 mask, 1 mode, 2 polarity, 3 pending clear |
| cfg_data_i | input | N_LINES | Write data, one bit per line |
| ack_i | input | 1 | Processor acknowledge strobe |
| boundary_i | input | 1 | High at instruction boundaries |
| irq_o | output | 1 | Interrupt request to the processor |
| irq_idx_o | output | $clog2(N_LINES) | Index of the selected maskable line |
| nmi_o | output | 1 | Non-maskable request being presented |
| status_o | output | N_LINES | Per-line request status before masking |

## Verification
On every cycle, the assertions check these rules:
- a pending bit is kept until a clear reaches it;
- a detected edge always sets its pending bit, even when a clear arrives in the same cycle;
- a clear with no competing edge takes effect;
- the presented index always points at a requesting line;
- nothing is presented while the boundary strobe is low.

Some behaviours depend on the path from the raw inputs, so only the bench's scenarios can show them:
- the two-flop synchronizer latency;
- a single pending event for a long held input;
- survival of a pending bit across a masked period;
- an acknowledge that is absorbed by the non-maskable request;
- an acknowledge that coincides with a fresh edge;
- active-low polarity.

The bench's reference model covers these by comparing every output on every clock.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    typedef enum logic [1:0] {
        CFG_MASK = 2'd0,
        CFG_MODE = 2'd1,
        CFG_POL  = 2'd2,
        CFG_CLR  = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_st_t;

    sync_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.stg[0] = async_i;
        for (int k = 1; k < STAGES; k++) begin
            s_d.stg[k] = s_q.stg[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_o = s_q.stg[STAGES-1];
endmodule

// File: rtl/irq_lines.sv
module irq_lines
    import irq_ctrl_pkg::*;
#(
    parameter int N                = 8,
    parameter bit MASK_SET_ENABLES = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sync_i,
    input  logic         cfg_we_i,
    input  logic [1:0]   cfg_sel_i,
    input  logic [N-1:0] cfg_data_i,
    input  logic [N-1:0] ack_clr_i,
    output logic [N-1:0] req_o,
    output logic [N-1:0] elig_o
);
    localparam logic [N-1:0] MASK_RST = MASK_SET_ENABLES ? '0 : '1;

    typedef struct packed {
        logic [N-1:0] mask;
        logic [N-1:0] mode;
        logic [N-1:0] pol;
        logic [N-1:0] prev;
        logic [N-1:0] pend;
    } line_st_t;

    line_st_t     s_d, s_q;
    logic [N-1:0] active, edge_hit, clr_all, enable;
    cfg_sel_e     sel;

    assign sel = cfg_sel_e'(cfg_sel_i);

    always_comb begin
        active   = sync_i ^ s_q.pol;
        edge_hit = active & ~s_q.prev;
        clr_all  = ack_clr_i | ((cfg_we_i && sel == CFG_CLR) ? cfg_data_i : '0);
        s_d      = s_q;
        s_d.prev = active;
        s_d.pend = (s_q.pend & ~clr_all) | (edge_hit & s_q.mode);
        if (cfg_we_i) begin
            case (sel)
                CFG_MASK: s_d.mask = cfg_data_i;
                CFG_MODE: s_d.mode = cfg_data_i;
                CFG_POL:  s_d.pol  = cfg_data_i;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mask <= MASK_RST;
        end else begin
            s_q <= s_d;
        end
    end

    generate
        if (MASK_SET_ENABLES) begin : g_mask_en
            assign enable = s_q.mask;
        end else begin : g_mask_dis
            assign enable = ~s_q.mask;
        end
    endgenerate

    assign req_o  = (s_q.mode & s_q.pend) | (~s_q.mode & active);
    assign elig_o = req_o & enable;

    generate
        for (genvar g = 0; g < N; g++) begin : g_chk
            // R4
            pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                s_q.pend[g] && !clr_all[g] |=> s_q.pend[g]);
            // R8
            edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                edge_hit[g] && s_q.mode[g] |=> s_q.pend[g]);
            // R9
            clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
                clr_all[g] && !(edge_hit[g] && s_q.mode[g]) |=> !s_q.pend[g]);
        end
    endgenerate
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N    = 8,
    parameter int IDXW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    elig_i,
    output logic [IDXW-1:0] idx_o,
    output logic            valid_o
);
    always_comb begin
        idx_o   = '0;
        valid_o = 1'b0;
        for (int k = N - 1; k >= 0; k--) begin
            if (elig_i[k]) begin
                idx_o   = IDXW'(k);
                valid_o = 1'b1;
            end
        end
    end

    // R6
    pick_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> elig_i[idx_o]);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int  N_LINES          = 8,
    parameter int  SYNC_STAGES      = 2,
    parameter bit  MASK_SET_ENABLES = 1'b1,
    localparam int IDXW             = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req_raw_i,
    input  logic               nmi_raw_i,
    input  logic               cfg_we_i,
    input  logic [1:0]         cfg_sel_i,
    input  logic [N_LINES-1:0] cfg_data_i,
    input  logic               ack_i,
    input  logic               boundary_i,
    output logic               irq_o,
    output logic [IDXW-1:0]    irq_idx_o,
    output logic               nmi_o,
    output logic [N_LINES-1:0] status_o
);
    logic [N_LINES:0]   synced;
    logic [N_LINES-1:0] elig, ack_clr;
    logic               nmi_s, pick_valid;
    logic [IDXW-1:0]    pick_idx;

    irq_sync #(.W(N_LINES + 1), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({nmi_raw_i, req_raw_i}),
        .sync_o  (synced)
    );

    assign nmi_s = synced[N_LINES];

    irq_lines #(.N(N_LINES), .MASK_SET_ENABLES(MASK_SET_ENABLES)) u_lines (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_i     (synced[N_LINES-1:0]),
        .cfg_we_i   (cfg_we_i),
        .cfg_sel_i  (cfg_sel_i),
        .cfg_data_i (cfg_data_i),
        .ack_clr_i  (ack_clr),
        .req_o      (status_o),
        .elig_o     (elig)
    );

    irq_pick #(.N(N_LINES), .IDXW(IDXW)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .elig_i  (elig),
        .idx_o   (pick_idx),
        .valid_o (pick_valid)
    );

    always_comb begin
        ack_clr = '0;
        if (ack_i && boundary_i && pick_valid && !nmi_s) begin
            ack_clr[pick_idx] = 1'b1;
        end
    end

    assign irq_o     = boundary_i && (nmi_s || pick_valid);
    assign nmi_o     = boundary_i && nmi_s;
    assign irq_idx_o = pick_idx;

    // R7
    quiet_off_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary_i |-> !irq_o && !nmi_o);
    // R5
    nmi_implies_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |-> irq_o);
    // R6
    idx_requesting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !nmi_o |-> status_o[irq_idx_o]);
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
    localparam int N    = 8;
    localparam int IDXW = $clog2(N);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   raw = '0;
    logic           nmi = 1'b0;
    logic           we = 1'b0;
    logic [1:0]     sel = 2'd0;
    logic [N-1:0]   dat = '0;
    logic           ack = 1'b0;
    logic           bnd = 1'b0;
    logic           irq_o, nmi_o;
    logic [IDXW-1:0] idx_o;
    logic [N-1:0]   status_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // reference model state
    logic [N:0]   syncq[$];
    logic [N-1:0] m_mask, m_mode, m_pol, m_prev, m_pend;

    always #10 clk = ~clk;

    prio_irq_ctrl #(.N_LINES(N)) dut (
        .clk(clk), .rst_n(rst_n), .req_raw_i(raw), .nmi_raw_i(nmi),
        .cfg_we_i(we), .cfg_sel_i(sel), .cfg_data_i(dat), .ack_i(ack),
        .boundary_i(bnd), .irq_o(irq_o), .irq_idx_o(idx_o), .nmi_o(nmi_o),
        .status_o(status_o)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_out(output logic m_irq, output logic m_nmi,
                             output int m_idx, output logic m_valid,
                             output logic [N-1:0] m_st);
        logic [N:0]   s2;
        logic [N-1:0] act, el;
        s2      = syncq[0];
        act     = s2[N-1:0] ^ m_pol;
        m_st    = (m_mode & m_pend) | (~m_mode & act);
        el      = m_st & m_mask;
        m_valid = 1'b0;
        m_idx   = 0;
        for (int i = 0; i < N; i++) begin
            if (el[i] && !m_valid) begin
                m_valid = 1'b1;
                m_idx   = i;
            end
        end
        m_nmi = bnd && s2[N];
        m_irq = bnd && (s2[N] || m_valid);
    endtask

    task automatic model_step();
        logic m_irq, m_nmi, m_valid;
        int m_idx;
        logic [N-1:0] m_st, act, edg, clr;
        logic [N:0]   s2;
        model_out(m_irq, m_nmi, m_idx, m_valid, m_st);
        s2  = syncq[0];
        act = s2[N-1:0] ^ m_pol;
        edg = act & ~m_prev;
        clr = (we && sel == 2'd3) ? dat : '0;
        if (ack && bnd && m_valid && !s2[N]) clr[m_idx] = 1'b1;
        m_pend = (m_pend & ~clr) | (edg & m_mode);
        m_prev = act;
        if (we && sel == 2'd0) m_mask = dat;
        if (we && sel == 2'd1) m_mode = dat;
        if (we && sel == 2'd2) m_pol  = dat;
        void'(syncq.pop_front());
        syncq.push_back({nmi, raw});
    endtask

    task automatic compare();
        logic m_irq, m_nmi, m_valid;
        int m_idx;
        logic [N-1:0] m_st;
        model_out(m_irq, m_nmi, m_idx, m_valid, m_st);
        chk("R7 irq_o model", int'(irq_o), int'(m_irq));
        chk("R5 nmi_o model", int'(nmi_o), int'(m_nmi));
        chk("R6 idx model", int'(idx_o), m_idx);
        chk("R3 status model", int'(status_o), int'(m_st));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        #5;
        compare();
    endtask

    task automatic wr(logic [1:0] s, logic [N-1:0] d);
        we = 1'b1; sel = s; dat = d;
        cyc();
        we = 1'b0; dat = '0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        syncq = {};
        syncq.push_back('0);
        syncq.push_back('0);
        m_mask = '0; m_mode = '0; m_pol = '0; m_prev = '0; m_pend = '0;
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        bnd = 1'b1;
        #1;
        // R11 reset state
        chk("R11 irq_o", int'(irq_o), 0);
        chk("R11 status", int'(status_o), 0);

        // R1 sync latency, R4 masked after reset
        raw = 8'h08;
        cyc();
        chk("R1 one edge", int'(status_o[3]), 0);
        cyc();
        chk("R1 two edges", int'(status_o[3]), 1);
        chk("R4 masked", int'(irq_o), 0);

        wr(2'd0, 8'hFF);
        chk("R4 unmasked irq", int'(irq_o), 1);
        chk("R6 idx 3", int'(idx_o), 3);

        raw = 8'h0A;
        cyc(); cyc();
        chk("R6 lowest wins", int'(idx_o), 1);

        raw = 8'h00;
        cyc(); cyc();
        chk("R2 released", int'(status_o), 0);
        chk("R2 irq dropped", int'(irq_o), 0);

        // R7 boundary gating
        raw = 8'h20; bnd = 1'b0;
        cyc(); cyc();
        chk("R7 gated irq", int'(irq_o), 0);
        chk("R7 status kept", int'(status_o[5]), 1);
        bnd = 1'b1;
        cyc();
        chk("R7 presented", int'(irq_o), 1);
        chk("R6 idx 5", int'(idx_o), 5);
        raw = 8'h00;
        cyc(); cyc();

        // R3 edge mode on line 2
        wr(2'd1, 8'h04);
        raw = 8'h04; cyc(); raw = 8'h00; cyc(); cyc();
        chk("R3 pending set", int'(status_o[2]), 1);
        chk("R6 idx 2", int'(idx_o), 2);
        cyc(); cyc();
        chk("R3 sticky", int'(status_o[2]), 1);
        ack = 1'b1; cyc(); ack = 1'b0;
        chk("R8 ack clears", int'(status_o[2]), 0);

        raw = 8'h04; cyc(); cyc(); cyc();
        chk("R3 held sets once", int'(status_o[2]), 1);
        ack = 1'b1; cyc(); ack = 1'b0;
        cyc(); cyc(); cyc();
        chk("R3 no re-raise while held", int'(status_o[2]), 0);
        raw = 8'h00; cyc(); cyc();

        // R4 pending survives mask, R9 clear write
        wr(2'd0, 8'hFB);
        raw = 8'h04; cyc(); raw = 8'h00; cyc(); cyc();
        chk("R4 pending while masked", int'(status_o[2]), 1);
        chk("R4 masked no irq", int'(irq_o), 0);
        cyc(); cyc();
        chk("R4 pending kept", int'(status_o[2]), 1);
        wr(2'd0, 8'hFF);
        chk("R4 unmask presents", int'(irq_o), 1);
        chk("R4 unmask idx", int'(idx_o), 2);
        wr(2'd3, 8'h04);
        chk("R9 clear write", int'(status_o[2]), 0);
        chk("R9 irq gone", int'(irq_o), 0);

        // R5 non-maskable
        wr(2'd0, 8'h00);
        nmi = 1'b1; cyc(); cyc();
        chk("R5 nmi_o", int'(nmi_o), 1);
        chk("R5 irq with nmi", int'(irq_o), 1);
        bnd = 1'b0; cyc();
        chk("R7 nmi gated", int'(nmi_o), 0);
        chk("R7 irq gated", int'(irq_o), 0);
        bnd = 1'b1;
        wr(2'd0, 8'hFF);
        raw = 8'h04; cyc(); raw = 8'h00; cyc(); cyc();
        ack = 1'b1; cyc(); ack = 1'b0;
        chk("R5 ack taken by nmi", int'(status_o[2]), 1);
        nmi = 1'b0; cyc(); cyc();
        chk("R5 nmi released", int'(nmi_o), 0);
        chk("R5 line presented", int'(idx_o), 2);

        // R8 new edge in the acknowledge cycle
        raw = 8'h04; cyc(); cyc();
        ack = 1'b1; cyc(); ack = 1'b0; raw = 8'h00;
        chk("R8 edge wins over ack", int'(status_o[2]), 1);
        ack = 1'b1; cyc(); ack = 1'b0;
        chk("R8 second ack clears", int'(status_o[2]), 0);

        // R10 active-low polarity in level mode
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h40);
        chk("R10 low is active", int'(status_o[6]), 1);
        chk("R10 idx 6", int'(idx_o), 6);
        raw = 8'h40; cyc(); cyc();
        chk("R10 high is idle", int'(status_o[6]), 0);
        cyc();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule